// File: doc/BRIEF.md
# Counted Loop Branch Unit

This unit resolves a counted-loop branch in an in-order pipeline. For each branch it gets the decoded control fields, the condition register, the loop counter and the address of the next instruction. It can first decrement the counter by one. It then picks one condition bit and compares it with the requested sense, where exit is 1 and iterate is 0. The branch is taken only when that comparison holds and the counter, after the optional decrement, equals zero. The target is the next-instruction address plus the signed byte offset.

A branch may carry a nonzero delay count. That many following instructions retire before the redirect takes effect. If the branch is not taken, those instructions are cancelled instead. A taken branch with a zero offset raises a trap in place of a redirect. A branch that arrives while a delay window is still open is refused and flagged as an error. The decremented counter is written back whenever a decrement was requested, whether or not the branch is taken.

Top module: `counted_loop_br`

## Requirements
- R1: After reset, redirect_valid, trap, err, cnt_wb_valid, cancel and cleave_busy are all 0.
- R2: With a zero delay count, a taken branch pulses redirect_valid for one cycle, on the cycle after br_valid. redirect_pc then equals next_pc plus the sign-extended byte offset.
- R3: When br_dec is 1 on an accepted branch, cnt_wb_valid pulses on the following cycle with cnt_wb_data equal to cnt_in minus one, whether or not the branch is taken. When br_dec is 0 there is no writeback.
- R4: The branch is taken only when cond_reg[cond_sel] equals br_sense (1 exits, 0 iterates) and the counter after the optional decrement is zero. A not-taken branch with a zero delay count produces no redirect and no cancel.
- R5: With a delay count N>0 on a taken branch, cleave_busy stays high and cancel stays low until N retire pulses have been seen. redirect_valid rises on the cycle after the Nth retire, with the target captured at the branch. Cycles without retire do not advance the count.
- R6: With a delay count N>0 on a not-taken branch, cancel and cleave_busy stay high until N retire pulses have been seen. Both then drop, and no redirect follows.
- R7: A taken branch whose offset is zero pulses trap on the next cycle, with no redirect and no delay window.
- R8: A branch presented while cleave_busy is high pulses err on the next cycle. That branch produces no writeback, redirect or trap, and the open window finishes unchanged.
- R9: cond_sel chooses which bit of cond_reg is used. Bit index 0 is the least significant bit.
- R10: A decrement of a zero counter wraps to all ones, so the branch is not taken and the written-back value is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch present this cycle |
| cond_reg | input | COND_W | Condition register value |
| cond_sel | input | SEL_W | Index of the condition bit |
| br_sense | input | 1 | 1 = exit sense, 0 = iterate sense |
| br_dec | input | 1 | Decrement the counter before the zero test |
| cnt_in | input | CNT_W | Loop counter value |
| br_offset | input | OFF_W | Signed byte offset from the next instruction |
| next_pc | input | PC_W | Address of the next instruction |
| cleave_cnt | input | CLV_W | Number of following instructions in the delay window |
| retire | input | 1 | One following instruction retires |
| redirect_valid | output | 1 | Redirect pulse |
| redirect_pc | output | PC_W | Redirect target |
| cancel | output | 1 | Instructions retiring now are to be discarded |
| cleave_busy | output | 1 | Delay window open |
| cnt_wb_valid | output | 1 | Counter writeback pulse |
| cnt_wb_data | output | CNT_W | Counter value to write back |
| trap | output | 1 | Taken branch with zero offset |
| err | output | 1 | Branch refused during an open window |

## Verification
A wrong remaining count in the delay window shows up at the ports as a redirect, or a drop of cancel, that comes early or late relative to the Nth retire. The bench sees this within one cycle of the expected retire. A wrong stored take decision or stored target only becomes visible when the window closes, as a missing redirect, a spurious redirect or a wrong redirect_pc. A fault in the condition or decrement path shows up on the cycle after br_valid as a wrong redirect, trap or writeback value.

// File: rtl/clb_pkg.sv
package clb_pkg;
  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_TRAP,
    ACT_NOW,
    ACT_DEFER
  } clb_act_e;

  function automatic clb_act_e clb_pick_act(input logic take, input logic off_zero,
                                            input logic delay_zero);
    if (take && off_zero) return ACT_TRAP;
    if (delay_zero) return ACT_NOW;
    return ACT_DEFER;
  endfunction
endpackage

// File: rtl/clb_eval.sv
module clb_eval #(
  parameter int PC_W   = 32,
  parameter int CNT_W  = 16,
  parameter int OFF_W  = 16,
  parameter int COND_W = 8,
  localparam int SEL_W = (COND_W > 1) ? $clog2(COND_W) : 1
) (
  input  logic [COND_W-1:0] cond_reg,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic              sense,
  input  logic              dec,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [OFF_W-1:0]  offset,
  input  logic [PC_W-1:0]   next_pc,
  output logic              take,
  output logic              off_zero,
  output logic [CNT_W-1:0]  cnt_next,
  output logic [PC_W-1:0]   target
);
  logic            cbit;
  logic [PC_W-1:0] off_ext;

  assign cbit     = cond_reg[cond_sel];
  assign cnt_next = dec ? cnt_in - CNT_W'(1) : cnt_in;
  assign take     = (cbit == sense) && (cnt_next == '0);
  assign off_zero = (offset == '0);
  assign off_ext  = PC_W'($signed(offset));
  assign target   = next_pc + off_ext;
endmodule

// File: rtl/clb_cleave_ctr.sv
module clb_cleave_ctr #(
  parameter int CLV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CLV_W-1:0] load_cnt,
  input  logic             retire,
  output logic             busy,
  output logic             last
);
  logic [CLV_W-1:0] remain;

  assign last = busy && retire && (remain == CLV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      remain <= load_cnt;
    end else if (busy && retire) begin
      remain <= remain - CLV_W'(1);
      if (remain == CLV_W'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/counted_loop_br.sv
module counted_loop_br #(
  parameter int PC_W   = 32,
  parameter int CNT_W  = 16,
  parameter int OFF_W  = 16,
  parameter int COND_W = 8,
  parameter int CLV_W  = 4,
  localparam int SEL_W = (COND_W > 1) ? $clog2(COND_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_valid,
  input  logic [COND_W-1:0] cond_reg,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic              br_sense,
  input  logic              br_dec,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [OFF_W-1:0]  br_offset,
  input  logic [PC_W-1:0]   next_pc,
  input  logic [CLV_W-1:0]  cleave_cnt,
  input  logic              retire,
  output logic              redirect_valid,
  output logic [PC_W-1:0]   redirect_pc,
  output logic              cancel,
  output logic              cleave_busy,
  output logic              cnt_wb_valid,
  output logic [CNT_W-1:0]  cnt_wb_data,
  output logic              trap,
  output logic              err
);
  import clb_pkg::*;

  logic             take, off_zero, accept, win_last;
  logic [CNT_W-1:0] cnt_next;
  logic [PC_W-1:0]  target;
  logic             held_take;
  logic [PC_W-1:0]  held_pc;
  clb_act_e         act;

  clb_eval #(
    .PC_W(PC_W), .CNT_W(CNT_W), .OFF_W(OFF_W), .COND_W(COND_W)
  ) u_eval (
    .cond_reg(cond_reg), .cond_sel(cond_sel), .sense(br_sense), .dec(br_dec),
    .cnt_in(cnt_in), .offset(br_offset), .next_pc(next_pc),
    .take(take), .off_zero(off_zero), .cnt_next(cnt_next), .target(target)
  );

  assign accept = br_valid && !cleave_busy;
  assign act    = clb_pick_act(take, off_zero, cleave_cnt == '0);

  clb_cleave_ctr #(.CLV_W(CLV_W)) u_ctr (
    .clk(clk), .rst(rst),
    .load(accept && (act == ACT_DEFER)),
    .load_cnt(cleave_cnt),
    .retire(retire),
    .busy(cleave_busy),
    .last(win_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      cancel         <= 1'b0;
      cnt_wb_valid   <= 1'b0;
      cnt_wb_data    <= '0;
      trap           <= 1'b0;
      err            <= 1'b0;
      held_take      <= 1'b0;
      held_pc        <= '0;
    end else begin
      redirect_valid <= 1'b0;
      trap           <= 1'b0;
      err            <= br_valid && cleave_busy;
      cnt_wb_valid   <= accept && br_dec;
      if (accept && br_dec) cnt_wb_data <= cnt_next;
      if (win_last) begin
        redirect_valid <= held_take;
        redirect_pc    <= held_pc;
        cancel         <= 1'b0;
      end
      if (accept) begin
        case (act)
          ACT_TRAP: trap <= 1'b1;
          ACT_NOW: begin
            redirect_valid <= take;
            if (take) redirect_pc <= target;
          end
          ACT_DEFER: begin
            held_take <= take;
            held_pc   <= target;
            cancel    <= !take;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/clb_checker.sv
module clb_checker (
  input logic clk,
  input logic rst,
  input logic br_valid,
  input logic br_dec,
  input logic retire,
  input logic redirect_valid,
  input logic cancel,
  input logic cleave_busy,
  input logic cnt_wb_valid,
  input logic trap,
  input logic err
);
  p_wb_on_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !cleave_busy && br_dec) |=> cnt_wb_valid);

  p_redirect_idle_r2: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> !cleave_busy);

  p_hold_window_r5: assert property (@(posedge clk) disable iff (rst)
    (cleave_busy && !retire) |=> cleave_busy);

  p_cancel_in_window_r6: assert property (@(posedge clk) disable iff (rst)
    cancel |-> cleave_busy);

  p_trap_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(trap && redirect_valid));

  p_refuse_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (cleave_busy && br_valid) |=> (err && !cnt_wb_valid && !trap));
endmodule

bind counted_loop_br clb_checker u_clb_checker (
  .clk(clk), .rst(rst), .br_valid(br_valid), .br_dec(br_dec), .retire(retire),
  .redirect_valid(redirect_valid), .cancel(cancel), .cleave_busy(cleave_busy),
  .cnt_wb_valid(cnt_wb_valid), .trap(trap), .err(err)
);

// File: tb/test_counted_loop_br.sv
module test_counted_loop_br;
  localparam int PC_W = 32, CNT_W = 16, OFF_W = 16, COND_W = 8, CLV_W = 4, SEL_W = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic br_valid = 0, br_sense = 0, br_dec = 0, retire = 0;
  logic [COND_W-1:0] cond_reg = '0;
  logic [SEL_W-1:0]  cond_sel = '0;
  logic [CNT_W-1:0]  cnt_in = '0;
  logic [OFF_W-1:0]  br_offset = '0;
  logic [PC_W-1:0]   next_pc = '0;
  logic [CLV_W-1:0]  cleave_cnt = '0;
  logic redirect_valid, cancel, cleave_busy, cnt_wb_valid, trap, err;
  logic [PC_W-1:0]  redirect_pc;
  logic [CNT_W-1:0] cnt_wb_data;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  counted_loop_br i_counted_loop_br (.*);

  typedef struct packed {
    logic [7:0]  cr;
    logic [2:0]  sel;
    logic        sense;
    logic        dec;
    logic [15:0] cnt;
    logic [15:0] off;
    logic [31:0] npc;
    logic        e_red;
    logic        e_trap;
    logic [31:0] e_pc;
    logic [15:0] e_wb;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 3'd0, 1'b1, 1'b1, 16'd1, 16'h0010, 32'h1000, 1'b1, 1'b0, 32'h1010, 16'h0000},
    '{8'h01, 3'd0, 1'b1, 1'b1, 16'd5, 16'h0010, 32'h1000, 1'b0, 1'b0, 32'h0,    16'h0004},
    '{8'h00, 3'd0, 1'b0, 1'b0, 16'd0, 16'hFFF0, 32'h2000, 1'b1, 1'b0, 32'h1FF0, 16'h0000},
    '{8'h80, 3'd7, 1'b1, 1'b0, 16'd0, 16'h0008, 32'h0300, 1'b1, 1'b0, 32'h0308, 16'h0000},
    '{8'h80, 3'd6, 1'b1, 1'b0, 16'd0, 16'h0008, 32'h0300, 1'b0, 1'b0, 32'h0,    16'h0000},
    '{8'h01, 3'd0, 1'b1, 1'b1, 16'd0, 16'h0008, 32'h0300, 1'b0, 1'b0, 32'h0,    16'hFFFF},
    '{8'h01, 3'd0, 1'b1, 1'b1, 16'd1, 16'h0000, 32'h0040, 1'b0, 1'b1, 32'h0,    16'h0000},
    '{8'h01, 3'd0, 1'b0, 1'b0, 16'd0, 16'h0004, 32'h0040, 1'b0, 1'b0, 32'h0,    16'h0000}
  };

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic put_br(input vec_t v, input logic [3:0] clv);
    cond_reg = v.cr; cond_sel = v.sel; br_sense = v.sense; br_dec = v.dec;
    cnt_in = v.cnt; br_offset = v.off; next_pc = v.npc; cleave_cnt = clv; br_valid = 1;
  endtask

  task automatic do_retire();
    retire = 1;
    @(negedge clk);
    retire = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      report();
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({redirect_valid, trap, err, cnt_wb_valid, cancel, cleave_busy} == 6'b0, "R1",
        {redirect_valid, trap, err, cnt_wb_valid, cancel, cleave_busy}, 0);
    rst = 0;
    @(negedge clk);

    // table: R2 R3 R4 R7 R9 R10 with zero delay count
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      put_br(v, 4'd0);
      @(negedge clk);
      br_valid = 0;
      chk(redirect_valid == v.e_red, "R2/R4/R9 redirect", redirect_valid, v.e_red);
      if (v.e_red) chk(redirect_pc == v.e_pc, "R2 target", redirect_pc, v.e_pc);
      chk(trap == v.e_trap, "R7 trap", trap, v.e_trap);
      chk(cnt_wb_valid == v.dec, "R3 wb valid", cnt_wb_valid, v.dec);
      if (v.dec) chk(cnt_wb_data == v.e_wb, "R3/R10 wb data", cnt_wb_data, v.e_wb);
      chk(cancel == 0 && cleave_busy == 0, "R4/R7 no window", {cancel, cleave_busy}, 0);
      @(negedge clk);
    end

    // R5 taken with delay 3
    put_br(VECS[0], 4'd3);
    @(negedge clk);
    br_valid = 0;
    chk(cleave_busy && !cancel && !redirect_valid, "R5 open", {cleave_busy, cancel, redirect_valid}, 3'b100);
    do_retire();
    @(negedge clk);
    do_retire();
    chk(cleave_busy && !redirect_valid, "R5 still open", {cleave_busy, redirect_valid}, 2'b10);
    do_retire();
    chk(redirect_valid && redirect_pc == 32'h1010, "R5 redirect", redirect_pc, 32'h1010);
    chk(!cleave_busy, "R5 closed", cleave_busy, 0);
    @(negedge clk);
    chk(!redirect_valid, "R5 pulse", redirect_valid, 0);

    // R6 not taken with delay 2
    put_br(VECS[1], 4'd2);
    @(negedge clk);
    br_valid = 0;
    chk(cancel && cleave_busy, "R6 cancel", {cancel, cleave_busy}, 2'b11);
    do_retire();
    chk(cancel, "R6 cancel held", cancel, 1);
    do_retire();
    chk(!cancel && !cleave_busy && !redirect_valid, "R6 end", {cancel, cleave_busy, redirect_valid}, 0);

    // R8 branch refused while window open
    v = VECS[2];
    v.npc = 32'h0500; v.off = 16'h0020;
    put_br(v, 4'd2);
    @(negedge clk);
    put_br(VECS[0], 4'd0);
    @(negedge clk);
    br_valid = 0;
    chk(err && !cnt_wb_valid && !redirect_valid && !trap, "R8 refuse",
        {err, cnt_wb_valid, redirect_valid, trap}, 4'b1000);
    do_retire();
    chk(!err && cleave_busy, "R8 window kept", {err, cleave_busy}, 2'b01);
    do_retire();
    chk(redirect_valid && redirect_pc == 32'h0520, "R8 original target", redirect_pc, 32'h0520);

    repeat (2) @(negedge clk);
    report();
  end
endmodule